// File: doc/BRIEF.md
# Preset Commit Sequencer

This block owns the preset storage of a bank of digitally set potentiometers and sequences every change to it the way a slow nonvolatile cell would be written. The serial front end hands it a decoded request: a preset write with host data, a copy of one wiper into one of its presets, or a copy of every wiper into the same preset slot of each pot. The front end also hands it the chip-select level, a flag saying that a complete store frame was received, and the hardware write-protect input. The block opens a store only when chip select returns high after such a frame and write protect allows it.

A store keeps the block busy for a programmable number of system clocks. The target, the data and, for copies, the wiper values are captured when the store opens. The preset array changes only on the clock edge that ends the busy window. The write-in-progress bit is exported in a status byte for the status-read command. A busy line tells the register bank to hold off further preset-changing commands. A request that arrives while busy is dropped and raises a sticky rejected flag.

Top module: `preset_commit_seq`

## Requirements
- R1: After reset, busy_o, rejected_o and status_o are 0, and every preset reads 0.
- R2: A store opens only on the clock edge where cs_n_i is seen going from 0 to 1 while frame_done_i is 1. frame_done_i with cs_n_i held steady, or a chip-select rise without frame_done_i, opens nothing.
- R3: While store_en_i is 0, a request opens no store: busy_o stays 0, no preset changes, and rejected_o is not set.
- R4: Once a store opens, busy_o is 1 for exactly TWR_CYCLES clock cycles and then returns to 0.
- R5: status_o bit 0 equals the write-in-progress state (busy_o), and status_o bits 7..1 are 0.
- R6: No preset changes while busy_o is 1. The new value becomes readable on the edge where busy_o falls.
- R7: kind_i = 2'b00 stores data_i into preset reg_i of pot pot_i. kind_i = 2'b11 is not a store and opens nothing.
- R8: kind_i = 2'b01 stores the wiper of pot pot_i into its preset reg_i. The wiper value is taken on the opening edge, so later changes on wipers_i have no effect. Pot p's wiper is wipers_i[p*WBITS +: WBITS].
- R9: kind_i = 2'b10 stores every pot's wiper into that pot's preset reg_i, all in one store. pot_i is ignored.
- R10: A store request made while busy_o is 1 is dropped and sets rejected_o. rejected_o stays 1 until the next accepted request, whose opening edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip-select level from the serial pins, active low |
| frame_done_i | input | 1 | A complete preset-changing frame has been received |
| store_en_i | input | 1 | Hardware write-protect input; 0 forbids stores |
| kind_i | input | 2 | Request kind: 00 write, 01 copy one wiper, 10 copy all wipers, 11 none |
| pot_i | input | PW | Target pot |
| reg_i | input | RW | Target preset slot |
| data_i | input | WBITS | Host data for a preset write |
| wipers_i | input | NPOT*WBITS | Current wiper positions of all pots |
| rd_pot_i | input | PW | Read port pot select |
| rd_reg_i | input | RW | Read port slot select |
| rd_data_o | output | WBITS | Preset value at the read address |
| busy_o | output | 1 | Store in progress; blocks preset-changing commands |
| status_o | output | 8 | Status byte, bit 0 is write-in-progress |
| rejected_o | output | 1 | Sticky flag: a request was dropped while busy |

## Verification
A wrong capture register shows up only at the end of the window, when the read port returns a value that differs from the model. For a copy, this happens even if the wipers were changed on purpose during the window. A timer off by one shows on busy_o at the first or last cycle of the window. The window is short in the bench, so the fault appears within a dozen clocks of the opening edge. Faulty admission shows at once: busy_o rises a cycle after a frame that should have been refused, or stays low after one that should have opened a store. The bench checks the preset contents every cycle of the window, so an early commit cannot go unnoticed.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        KIND_WRITE    = 2'b00,
        KIND_COPY_ONE = 2'b01,
        KIND_COPY_ALL = 2'b10,
        KIND_NONE     = 2'b11
    } req_kind_e;

    localparam int STATUS_W = 8;

    function automatic logic kind_stores(input req_kind_e k);
        return k != KIND_NONE;
    endfunction

endpackage

// File: rtl/pcs_admit.sv
module pcs_admit
    import pcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n_i,
    input  logic      frame_done_i,
    input  logic      store_en_i,
    input  req_kind_e kind_i,
    input  logic      busy_i,
    output logic      start_o,
    output logic      rejected_o
);
    logic cs_q;
    logic cs_rise;
    logic req;

    always_ff @(posedge clk) begin
        if (rst) cs_q <= 1'b1;
        else     cs_q <= cs_n_i;
    end

    assign cs_rise = cs_n_i & ~cs_q;
    assign req     = cs_rise & frame_done_i & kind_stores(kind_i) & store_en_i;
    assign start_o = req & ~busy_i;

    always_ff @(posedge clk) begin
        if (rst)               rejected_o <= 1'b0;
        else if (start_o)      rejected_o <= 1'b0;
        else if (req & busy_i) rejected_o <= 1'b1;
    end

    // R10
    sticky_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (rejected_o && !start_o) |=> rejected_o);

endmodule

// File: rtl/pcs_timer.sv
module pcs_timer #(
    parameter int TWR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(TWR_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt    <= CW'(TWR_CYCLES - 1);
        end else if (busy_o) begin
            if (cnt == '0) busy_o <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign done_o = busy_o && (cnt == '0);

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

endmodule

// File: rtl/pcs_bank.sv
module pcs_bank
    import pcs_pkg::*;
#(
    parameter int NPOT  = 4,
    parameter int NREG  = 4,
    parameter int WBITS = 6,
    localparam int PW = $clog2(NPOT),
    localparam int RW = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  req_kind_e             kind_i,
    input  logic [PW-1:0]         pot_i,
    input  logic [RW-1:0]         reg_i,
    input  logic [WBITS-1:0]      data_i,
    input  logic [NPOT*WBITS-1:0] wipers_i,
    input  logic                  commit_i,
    input  logic [PW-1:0]         rd_pot_i,
    input  logic [RW-1:0]         rd_reg_i,
    output logic [WBITS-1:0]      rd_data_o
);
    logic [WBITS-1:0]           mem    [NPOT][NREG];
    logic [WBITS-1:0]           pend_d [NPOT];
    logic [NPOT-1:0]            pend_m;
    logic [RW-1:0]              pend_reg;
    logic [NPOT*NREG*WBITS-1:0] mem_flat;

    always_ff @(posedge clk) begin
        if (rst)          pend_reg <= '0;
        else if (start_i) pend_reg <= reg_i;
    end

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_d[p] <= '0;
                pend_m[p] <= 1'b0;
            end else if (start_i) begin
                pend_m[p] <= (kind_i == KIND_COPY_ALL) || (pot_i == PW'(p));
                pend_d[p] <= (kind_i == KIND_WRITE) ? data_i
                                                    : wipers_i[p*WBITS +: WBITS];
            end
        end

        for (genvar r = 0; r < NREG; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    mem[p][r] <= '0;
                else if (commit_i && pend_m[p] && (pend_reg == RW'(r)))
                    mem[p][r] <= pend_d[p];
            end
            assign mem_flat[(p*NREG + r)*WBITS +: WBITS] = mem[p][r];
        end
    end

    assign rd_data_o = mem[rd_pot_i][rd_reg_i];

    // R6
    store_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(mem_flat));

endmodule

// File: rtl/preset_commit_seq.sv
module preset_commit_seq
    import pcs_pkg::*;
#(
    parameter int NPOT       = 4,
    parameter int NREG       = 4,
    parameter int WBITS      = 6,
    parameter int TWR_CYCLES = 1000,
    localparam int PW = $clog2(NPOT),
    localparam int RW = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n_i,
    input  logic                  frame_done_i,
    input  logic                  store_en_i,
    input  logic [1:0]            kind_i,
    input  logic [PW-1:0]         pot_i,
    input  logic [RW-1:0]         reg_i,
    input  logic [WBITS-1:0]      data_i,
    input  logic [NPOT*WBITS-1:0] wipers_i,
    input  logic [PW-1:0]         rd_pot_i,
    input  logic [RW-1:0]         rd_reg_i,
    output logic [WBITS-1:0]      rd_data_o,
    output logic                  busy_o,
    output logic [STATUS_W-1:0]   status_o,
    output logic                  rejected_o
);
    req_kind_e kind;
    logic      start;
    logic      done;

    assign kind = req_kind_e'(kind_i);

    pcs_admit u_admit (
        .clk         (clk),
        .rst         (rst),
        .cs_n_i      (cs_n_i),
        .frame_done_i(frame_done_i),
        .store_en_i  (store_en_i),
        .kind_i      (kind),
        .busy_i      (busy_o),
        .start_o     (start),
        .rejected_o  (rejected_o)
    );

    pcs_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start_i(start),
        .busy_o (busy_o),
        .done_o (done)
    );

    pcs_bank #(.NPOT(NPOT), .NREG(NREG), .WBITS(WBITS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .kind_i   (kind),
        .pot_i    (pot_i),
        .reg_i    (reg_i),
        .data_i   (data_i),
        .wipers_i (wipers_i),
        .commit_i (done),
        .rd_pot_i (rd_pot_i),
        .rd_reg_i (rd_reg_i),
        .rd_data_o(rd_data_o)
    );

    assign status_o = {{(STATUS_W-1){1'b0}}, busy_o};

    // R2
    open_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_o);

    // R3
    protect_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        !store_en_i |=> !$rose(busy_o));

endmodule

// File: tb/preset_commit_seq_tb.sv
module preset_commit_seq_tb_top;
    localparam int TWR = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, frame_done = 1'b0, store_en = 1'b1;
    logic [1:0]  kind = 2'b11, pot = '0, rsel = '0, rd_pot = '0, rd_reg = '0;
    logic [5:0]  data = '0, rd_data;
    logic [23:0] wipers = '0, snap;
    logic        busy, rejected;
    logic [7:0]  status;
    logic [5:0]  model [4][4];
    int          checks = 0, failures = 0, cyc = 0;

    always #4 clk = ~clk;

    preset_commit_seq #(.NPOT(4), .NREG(4), .WBITS(6), .TWR_CYCLES(TWR)) dut_i (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .frame_done_i(frame_done),
        .store_en_i(store_en), .kind_i(kind), .pot_i(pot), .reg_i(rsel),
        .data_i(data), .wipers_i(wipers), .rd_pot_i(rd_pot), .rd_reg_i(rd_reg),
        .rd_data_o(rd_data), .busy_o(busy), .status_o(status), .rejected_o(rejected)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_val(input logic [1:0] k, input int p,
                                           input logic [5:0] d, input logic [23:0] w);
        return (k == 2'b00) ? d : w[p*6 +: 6];
    endfunction

    function automatic bit hits(input logic [1:0] k, input int p, input logic [1:0] tp);
        return (k == 2'b10) || ((k == 2'b00 || k == 2'b01) && p == int'(tp));
    endfunction

    task automatic apply(input logic [1:0] k, input logic [1:0] tp, input logic [1:0] tr,
                         input logic [5:0] d, input logic [23:0] w);
        for (int p = 0; p < 4; p++)
            if (hits(k, p, tp)) model[p][tr] = exp_val(k, p, d, w);
    endtask

    task automatic check_all(input string req);
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) begin
                rd_pot = 2'(p); rd_reg = 2'(r);
                #1;
                chk(rd_data == model[p][r], req, rd_data, model[p][r]);
            end
    endtask

    // Returns at the first negedge after the chip-select rise was seen.
    task automatic frame(input logic [1:0] k, input logic [1:0] tp, input logic [1:0] tr,
                         input logic [5:0] d);
        @(negedge clk); cs_n = 1'b0; frame_done = 1'b0;
        @(negedge clk); kind = k; pot = tp; rsel = tr; data = d; frame_done = 1'b1;
        snap = wipers;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic finish_store(input logic [1:0] k, input logic [1:0] tp,
                                input logic [1:0] tr, input logic [5:0] d,
                                input logic [23:0] w, input string req);
        logic [1:0] vp;
        vp = (k == 2'b10) ? 2'd0 : tp;
        rd_pot = vp; rd_reg = tr; #1;
        chk(busy == 1'b1, "R4", busy, 1);
        chk(status == 8'h01, "R5", status, 1);
        for (int i = 1; i < TWR; i++) begin
            @(negedge clk);
            if (k == 2'b01) wipers = 24'($urandom);
            rd_pot = vp; rd_reg = tr; #1;
            chk(busy == 1'b1, "R4", busy, 1);
            chk(rd_data == model[vp][tr], "R6", rd_data, model[vp][tr]);
        end
        @(negedge clk);
        chk(busy == 1'b0, "R4", busy, 0);
        chk(status == 8'h00, "R5", status, 0);
        apply(k, tp, tr, d, w);
        check_all(req);
    endtask

    initial begin
        int unsigned seed;
        logic [1:0] k, tp, tr;
        logic [5:0] d;
        logic [23:0] w1;
        seed = $urandom(32'd1977);
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) model[p][r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", busy, 0);
        chk(rejected == 1'b0, "R1", rejected, 0);
        chk(status == 8'h00, "R1", status, 0);
        check_all("R1");

        // R2: frame_done with chip select held high, then a rise without frame_done
        kind = 2'b00; frame_done = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R2", busy, 0);
        frame_done = 1'b0; cs_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R2", busy, 0);

        // R7 write, then kind 11 opens nothing
        frame(2'b00, 2'd2, 2'd1, 6'h2A);
        finish_store(2'b00, 2'd2, 2'd1, 6'h2A, snap, "R7");
        frame(2'b11, 2'd1, 2'd1, 6'h11);
        chk(busy == 1'b0, "R7", busy, 0);
        check_all("R7");

        // R8 copy one wiper, wipers scrambled during busy
        wipers = 24'hA5C3_7E;
        frame(2'b01, 2'd1, 2'd3, 6'h00);
        w1 = snap;
        finish_store(2'b01, 2'd1, 2'd3, 6'h00, w1, "R8");

        // R9 global copy
        wipers = 24'h3F_0815;
        frame(2'b10, 2'd3, 2'd2, 6'h00);
        finish_store(2'b10, 2'd3, 2'd2, 6'h00, snap, "R9");

        // R3 write protect
        store_en = 1'b0;
        frame(2'b00, 2'd0, 2'd0, 6'h3F);
        chk(busy == 1'b0, "R3", busy, 0);
        chk(rejected == 1'b0, "R3", rejected, 0);
        repeat (TWR + 2) @(negedge clk);
        check_all("R3");
        store_en = 1'b1;

        // R10 request while busy
        frame(2'b00, 2'd0, 2'd1, 6'h15);
        frame(2'b00, 2'd3, 2'd3, 6'h2B);
        chk(rejected == 1'b1, "R10", rejected, 1);
        while (busy) @(negedge clk);
        apply(2'b00, 2'd0, 2'd1, 6'h15, 24'h0);
        check_all("R10");
        chk(rejected == 1'b1, "R10", rejected, 1);
        frame(2'b00, 2'd1, 2'd0, 6'h07);
        chk(rejected == 1'b0, "R10", rejected, 0);
        finish_store(2'b00, 2'd1, 2'd0, 6'h07, snap, "R10");

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            k  = 2'($urandom_range(0, 2));
            tp = 2'($urandom);
            tr = 2'($urandom);
            d  = 6'($urandom);
            wipers   = 24'($urandom);
            store_en = ($urandom_range(0, 5) != 0);
            frame(k, tp, tr, d);
            if (store_en) begin
                w1 = snap;
                finish_store(k, tp, tr, d, w1, k == 2'b00 ? "R7" : (k == 2'b01 ? "R8" : "R9"));
            end else begin
                chk(busy == 1'b0, "R3", busy, 0);
                check_all("R3");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule